// File: doc/BRIEF.md
# Register-Driven VGA Colour Output

This block produces a 640x480, 60 Hz VGA signal whose colour comes straight from a processor register instead of a pixel memory. A pair of free-running counters walks the beam across each line and down each frame and generates the two active-low sync pulses. The low six bits of the register are copied into a colour holding stage on every pixel clock. That colour is shown only while the beam is inside the visible window, and it is forced to black everywhere else so the monitor never sees drive during blanking.

The processor writes the register only when an instruction completes, which takes on the order of a hundred pixel clocks or more. The screen therefore shows broad horizontal bands of constant colour. All eight output signals are packed onto one 8-pin header in a fixed interleaved order. The timing figures are parameters, and the defaults give standard 640x480 timing.

Top module: `vga_colour_out`

## Requirements
- R1: Header pins carry, from bit 0 to bit 7: red MSB, green MSB, blue MSB, vertical sync, red LSB, green LSB, blue LSB, horizontal sync. The register's colour field is bits [5:4] red, [3:2] green and [1:0] blue.
- R2: A line lasts H_VIS+H_FP+H_SYNC+H_BP pixel clocks, 800 by default. Horizontal sync (pin 7) is low exactly for pixel positions H_VIS+H_FP up to H_VIS+H_FP+H_SYNC-1, which is 656..751 by default, and high elsewhere.
- R3: A frame lasts V_VIS+V_FP+V_SYNC+V_BP lines, 525 by default. Vertical sync (pin 3) is low exactly on lines V_VIS+V_FP up to V_VIS+V_FP+V_SYNC-1, which is 490..491 by default, and high elsewhere.
- R4: All six colour pins are 0 whenever the pixel position is at or beyond H_VIS, or the line is at or beyond V_VIS.
- R5: Inside the visible window, the colour pins show the register value captured at the most recent rising clock edge. A write is therefore seen from the next pixel onward and stays until the register changes.
- R6: Register bits [7:6] have no effect on any header pin.
- R7: While rst_n is low, the position and line counters are held at zero, all colour pins are 0 and both sync pins are high. After release, the first rising edge moves the position counter to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| colour_reg_i | input | 8 | Live value of the processor's colour register; bits [5:0] are used |
| header_o | output | 8 | Packed colour and sync pins in header order |

## Verification
The sampling of a new register value and the blanking gate can act in the same cycle. This happens when a write lands on the pixel where the beam leaves or re-enters the visible window. The bench provokes this by changing the register on every clock for thousands of cycles, using a shortened line and frame so that many window edges and frame wraps occur. It also holds values for about a hundred clocks at a time, so some writes straddle those boundaries. At every sample, a bench model of position, line and held colour decides whether the pins must show the fresh value or black, and each sync pin is compared separately.

// File: rtl/vga_colour_out.sv
module vga_colour_out #(
  parameter int H_VIS  = 640,
  parameter int H_FP   = 16,
  parameter int H_SYNC = 96,
  parameter int H_BP   = 48,
  parameter int V_VIS  = 480,
  parameter int V_FP   = 10,
  parameter int V_SYNC = 2,
  parameter int V_BP   = 33
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] colour_reg_i,
  output logic [7:0] header_o
);
  localparam int H_TOT = H_VIS + H_FP + H_SYNC + H_BP;
  localparam int V_TOT = V_VIS + V_FP + V_SYNC + V_BP;
  localparam int HW = $clog2(H_TOT);
  localparam int VW = $clog2(V_TOT);

  logic [HW-1:0] h_cnt;
  logic [VW-1:0] v_cnt;
  logic [5:0]    colour_q;

  wire h_last  = (h_cnt == HW'(H_TOT - 1));
  wire v_last  = (v_cnt == VW'(V_TOT - 1));
  wire visible = (h_cnt < HW'(H_VIS)) && (v_cnt < VW'(V_VIS));
  wire hsync_n = !((h_cnt >= HW'(H_VIS + H_FP)) && (h_cnt < HW'(H_VIS + H_FP + H_SYNC)));
  wire vsync_n = !((v_cnt >= VW'(V_VIS + V_FP)) && (v_cnt < VW'(V_VIS + V_FP + V_SYNC)));
  wire [5:0] rgb = visible ? colour_q : 6'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h_cnt    <= '0;
      v_cnt    <= '0;
      colour_q <= '0;
    end else begin
      colour_q <= colour_reg_i[5:0];
      h_cnt    <= h_last ? '0 : h_cnt + 1'b1;
      if (h_last) v_cnt <= v_last ? '0 : v_cnt + 1'b1;
    end
  end

  assign header_o = {hsync_n, rgb[0], rgb[2], rgb[4], vsync_n, rgb[1], rgb[3], rgb[5]};

  a_r2_line_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (h_cnt == HW'(H_TOT - 1)) |=> (h_cnt == '0));

  a_r2_hsync_start: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(header_o[7]) |-> (h_cnt == HW'(H_VIS + H_FP)));

  a_r3_frame_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    ((h_cnt == HW'(H_TOT - 1)) && (v_cnt == VW'(V_TOT - 1))) |=> (v_cnt == '0));

  a_r3_line_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (h_cnt != HW'(H_TOT - 1)) |=> $stable(v_cnt));

  a_r4_blank_lines: assert property (@(posedge clk) disable iff (!rst_n)
    (v_cnt >= VW'(V_VIS)) |-> ((header_o[6:4] == 3'd0) && (header_o[2:0] == 3'd0)));

  a_r7_reset_hold: assert property (@(posedge clk)
    !rst_n |=> ((h_cnt == '0) && (v_cnt == '0) && (header_o == 8'h88)));
endmodule

// File: tb/vga_colour_out_tb_top.sv
module vga_colour_out_tb_top;
  localparam int SH_VIS = 16, SH_FP = 2, SH_SYNC = 3, SH_BP = 3;
  localparam int SV_VIS = 6,  SV_FP = 1, SV_SYNC = 2, SV_BP = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] colour = 8'h00;
  logic [7:0] hdr_small, hdr_big;
  int checks = 0;
  int errors = 0;
  int n = 0;
  bit done = 0;

  always #4 clk = ~clk;

  vga_colour_out #(.H_VIS(SH_VIS), .H_FP(SH_FP), .H_SYNC(SH_SYNC), .H_BP(SH_BP),
                   .V_VIS(SV_VIS), .V_FP(SV_FP), .V_SYNC(SV_SYNC), .V_BP(SV_BP))
    dut_i (.clk(clk), .rst_n(rst_n), .colour_reg_i(colour), .header_o(hdr_small));

  vga_colour_out dut_big (.clk(clk), .rst_n(rst_n), .colour_reg_i(colour), .header_o(hdr_big));

  function automatic bit vis_at(int cnt, int hv, int hf, int hs, int hb, int vv, int vf, int vs, int vb);
    int ht = hv + hf + hs + hb;
    int vt = vv + vf + vs + vb;
    return ((cnt % ht) < hv) && (((cnt / ht) % vt) < vv);
  endfunction

  function automatic logic [7:0] model(int cnt, logic [7:0] c, int hv, int hf, int hs, int hb,
                                       int vv, int vf, int vs, int vb);
    int ht = hv + hf + hs + hb;
    int vt = vv + vf + vs + vb;
    int h = cnt % ht;
    int v = (cnt / ht) % vt;
    logic [7:0] p;
    logic [5:0] k;
    k = vis_at(cnt, hv, hf, hs, hb, vv, vf, vs, vb) ? c[5:0] : 6'd0;
    p[0] = k[5]; p[4] = k[4];
    p[1] = k[3]; p[5] = k[2];
    p[2] = k[1]; p[6] = k[0];
    p[7] = !(h >= hv + hf && h < hv + hf + hs);
    p[3] = !(v >= vv + vf && v < vv + vf + vs);
    return p;
  endfunction

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp, logic [7:0] mask);
    checks++;
    if ((got & mask) !== (exp & mask)) begin
      errors++;
      $display("FAIL %s at n=%0d: got %02h expected %02h (mask %02h)", tag, n, got & mask, exp & mask, mask);
    end
  endtask

  task automatic compare_one(logic [7:0] got, bit big, string ctag);
    logic [7:0] e;
    bit vis;
    if (big) begin
      e = model(n, colour, 640, 16, 96, 48, 480, 10, 2, 33);
      vis = vis_at(n, 640, 16, 96, 48, 480, 10, 2, 33);
    end else begin
      e = model(n, colour, SH_VIS, SH_FP, SH_SYNC, SH_BP, SV_VIS, SV_FP, SV_SYNC, SV_BP);
      vis = vis_at(n, SH_VIS, SH_FP, SH_SYNC, SH_BP, SV_VIS, SV_FP, SV_SYNC, SV_BP);
    end
    check("R2 hsync", got, e, 8'h80);
    check("R3 vsync", got, e, 8'h08);
    check(vis ? ctag : "R4 blank", got, e, 8'h77);
  endtask

  task automatic step(logic [7:0] c, string ctag);
    colour = c;
    @(posedge clk);
    n++;
    @(negedge clk);
    compare_one(hdr_small, 1'b0, ctag);
    compare_one(hdr_big, 1'b1, ctag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < 3; i++) begin
      colour = 8'($urandom);
      @(posedge clk);
      @(negedge clk);
      check("R7 reset small", hdr_small, 8'h88, 8'hFF);
      check("R7 reset big", hdr_big, 8'h88, 8'hFF);
    end
    rst_n = 1'b1;
    n = 0;
    check("R7 release", hdr_small, 8'h88, 8'hFF);
  endtask

  initial begin
    void'($urandom(32'd1207));
    do_reset();
    for (int i = 0; i < 2200; i++) step(8'($urandom), "R5 colour");
    for (int i = 0; i < 360; i++) step(8'(6'd1 << ((i / 5) % 6)), "R1 pin order");
    for (int i = 0; i < 360; i++) step({2'($urandom), 6'h2A ^ 6'((i / 24) % 2 ? 6'h3F : 6'h00)}, "R6 upper bits");
    do_reset();
    step(8'h3F, "R7 first pixel");
    for (int i = 0; i < 8; i++) begin
      logic [7:0] hold = 8'($urandom);
      for (int j = 0; j < 100; j++) step(hold, "R5 held colour");
    end
    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule